// File: doc/BRIEF.md
# Pipelined Top-Four Selector

This block takes `N` keyed entries in parallel every clock cycle and delivers the four entries with the largest keys, ranked from largest to smallest. Each entry is a `KEY_W`-bit energy value with a `TAG_W`-bit position tag, and the tag stays attached to its key through every exchange. `N` is a power of two from 8 to 256. A new set of entries may be presented on every cycle, and the results come out in the same order after a fixed latency.

The network is a bitonic sorter pruned so that it keeps only four results. First, sorted pairs are formed. Next, the pairs are merged into sorted groups of four. Each following level halves the number of groups: it takes the pairwise maximum of one sorted four and the reverse of its neighbour, then re-sorts the four survivors in two compare layers. A final step combines the last two groups into one ordered group of four. This gives `3*log2(N) - 5` steps in total. Pipeline registers are spread evenly over these steps, and there are exactly `DEPTH` of them (1 <= `DEPTH` <= step count). This lets latency be traded against clock rate.

A compare ranks entries by key. When two keys are equal, the entry from the lower input lane ranks higher. To make this ordering strict, the network appends the inverted lane index below each key.

Top module: `topsel`

## Requirements
- R1: When `out_vld` is high, slot i of `out_key` (bits [i*KEY_W +: KEY_W], slot 0 = largest) holds the i-th largest key of the input set presented `DEPTH` cycles earlier (input lane l at bits [l*KEY_W +: KEY_W]). This holds wherever in the lanes the large keys are placed.
- R2: Slot i of `out_tag` (bits [i*TAG_W +: TAG_W]) is the tag that entered on the same lane as the key in slot i of `out_key`.
- R3: Among equal keys, the entry from the lower-numbered input lane is placed in the lower-numbered output slot.
- R4: `out_vld` repeats `in_vld` exactly `DEPTH` cycles later. Sets presented on consecutive cycles emerge on consecutive cycles.
- R5: A cycle with `in_vld` low gives a cycle with `out_vld` low `DEPTH` cycles later. Entries presented during that cycle do not alter the results of the valid sets around it.
- R6: While `rst_n` is low, and for the first `DEPTH` cycles after its release, `out_vld` is low. Sets still in flight when reset is asserted never emerge as valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the valid pipeline |
| in_key | input | N*KEY_W | Keys of all input lanes, lane l at [l*KEY_W +: KEY_W] |
| in_tag | input | N*TAG_W | Position tags, lane l at [l*TAG_W +: TAG_W] |
| in_vld | input | 1 | Input set is valid this cycle |
| out_key | output | 4*KEY_W | Four largest keys, slot 0 largest |
| out_tag | output | 4*TAG_W | Tags belonging to the keys in the same slots |
| out_vld | output | 1 | Output slots hold a valid result |

## Verification
A comparator that is wired to the wrong lane, or a compare with the wrong sense, shows up as a missing, duplicated or misordered key. A tag separated from its key shows up too. In every case the error appears in the very set that meets the fault, `DEPTH` cycles after that set is presented. Stimulus therefore covers random keys, keys that all tie, keys with few distinct values, and winners placed in the last lanes, so that every comparator decides at least once. A fault in the valid pipeline shifts or drops the on/off pattern of `out_vld` as soon as the first bubble or reset reaches the output. Such a fault is exposed by alternating and irregular valid patterns and by a reset issued while sets are in flight.

// File: rtl/topsel_pkg.sv
package topsel_pkg;

    typedef enum logic [2:0] {
        K_PAIR,    // sort adjacent pairs
        K_CROSS4,  // outer/inner exchange inside a group of four
        K_HALVE,   // keep max of group and reversed neighbour
        K_SPAN2,   // exchange at distance two inside a group
        K_ADJ,     // exchange at distance one inside a group
        K_FINAL    // last halving plus full re-sort of four
    } step_kind_e;

    function automatic int stage_total(input int lanes);
        return 3 * $clog2(lanes) - 5;
    endfunction

    function automatic step_kind_e kind_of(input int s, input int total);
        if (s == 0)         return K_PAIR;
        if (s == 1)         return K_CROSS4;
        if (s == 2)         return K_ADJ;
        if (s == total - 1) return K_FINAL;
        case ((s - 3) % 3)
            0:       return K_HALVE;
            1:       return K_SPAN2;
            default: return K_ADJ;
        endcase
    endfunction

    // spreads exactly depth registers over total steps, last one at the end
    function automatic bit reg_after(input int s, input int total, input int depth);
        return (((s + 1) * depth) / total) != ((s * depth) / total);
    endfunction

endpackage

// File: rtl/topsel_cas.sv
module topsel_cas #(
    parameter int EW = 18,
    parameter int KW = 14
) (
    input  logic [EW-1:0] a_i,
    input  logic [EW-1:0] b_i,
    output logic [EW-1:0] hi_o,
    output logic [EW-1:0] lo_o
);
    logic a_wins;

    assign a_wins = a_i[EW-1 -: KW] >= b_i[EW-1 -: KW];
    assign hi_o   = a_wins ? a_i : b_i;
    assign lo_o   = a_wins ? b_i : a_i;
endmodule

// File: rtl/topsel_pick.sv
module topsel_pick #(
    parameter int EW = 18,
    parameter int KW = 14
) (
    input  logic [EW-1:0] a_i,
    input  logic [EW-1:0] b_i,
    output logic [EW-1:0] y_o
);
    assign y_o = (a_i[EW-1 -: KW] >= b_i[EW-1 -: KW]) ? a_i : b_i;
endmodule

// File: rtl/topsel_step.sv
module topsel_step
    import topsel_pkg::*;
#(
    parameter int         LANES = 16,
    parameter int         EW    = 18,
    parameter int         KW    = 14,
    parameter step_kind_e KIND  = K_PAIR
) (
    input  logic [LANES*EW-1:0] bus_i,
    output logic [LANES*EW-1:0] bus_o
);
    localparam int GRP4 = LANES / 4;
    localparam int GRP8 = LANES / 8;

    logic [EW-1:0] a [LANES];
    logic [EW-1:0] o [LANES];

    for (genvar l = 0; l < LANES; l++) begin : g_io
        assign a[l] = bus_i[l*EW +: EW];
        assign bus_o[l*EW +: EW] = o[l];
    end

    case (KIND)
        K_PAIR: begin : g_pair
            for (genvar p = 0; p < LANES / 2; p++) begin : g_p
                topsel_cas #(.EW(EW), .KW(KW)) u_cas (
                    .a_i(a[2*p]), .b_i(a[2*p+1]), .hi_o(o[2*p]), .lo_o(o[2*p+1]));
            end
        end
        K_CROSS4: begin : g_cross
            for (genvar g = 0; g < GRP4; g++) begin : g_g
                topsel_cas #(.EW(EW), .KW(KW)) u_out (
                    .a_i(a[4*g]), .b_i(a[4*g+3]), .hi_o(o[4*g]), .lo_o(o[4*g+3]));
                topsel_cas #(.EW(EW), .KW(KW)) u_in (
                    .a_i(a[4*g+1]), .b_i(a[4*g+2]), .hi_o(o[4*g+1]), .lo_o(o[4*g+2]));
            end
        end
        K_SPAN2: begin : g_span
            for (genvar g = 0; g < GRP4; g++) begin : g_g
                topsel_cas #(.EW(EW), .KW(KW)) u_c0 (
                    .a_i(a[4*g]), .b_i(a[4*g+2]), .hi_o(o[4*g]), .lo_o(o[4*g+2]));
                topsel_cas #(.EW(EW), .KW(KW)) u_c1 (
                    .a_i(a[4*g+1]), .b_i(a[4*g+3]), .hi_o(o[4*g+1]), .lo_o(o[4*g+3]));
            end
        end
        K_ADJ: begin : g_adj
            for (genvar g = 0; g < GRP4; g++) begin : g_g
                topsel_cas #(.EW(EW), .KW(KW)) u_c0 (
                    .a_i(a[4*g]), .b_i(a[4*g+1]), .hi_o(o[4*g]), .lo_o(o[4*g+1]));
                topsel_cas #(.EW(EW), .KW(KW)) u_c1 (
                    .a_i(a[4*g+2]), .b_i(a[4*g+3]), .hi_o(o[4*g+2]), .lo_o(o[4*g+3]));
            end
        end
        K_HALVE: begin : g_halve
            for (genvar g = 0; g < GRP8; g++) begin : g_g
                for (genvar i = 0; i < 4; i++) begin : g_i
                    topsel_pick #(.EW(EW), .KW(KW)) u_pick (
                        .a_i(a[8*g+i]), .b_i(a[8*g+7-i]), .y_o(o[4*g+i]));
                end
            end
            for (genvar l = LANES / 2; l < LANES; l++) begin : g_pass
                assign o[l] = a[l];
            end
        end
        default: begin : g_final
            logic [EW-1:0] m [4];
            logic [EW-1:0] p [4];
            for (genvar i = 0; i < 4; i++) begin : g_i
                topsel_pick #(.EW(EW), .KW(KW)) u_pick (
                    .a_i(a[i]), .b_i(a[7-i]), .y_o(m[i]));
            end
            topsel_cas #(.EW(EW), .KW(KW)) u_s0 (
                .a_i(m[0]), .b_i(m[2]), .hi_o(p[0]), .lo_o(p[2]));
            topsel_cas #(.EW(EW), .KW(KW)) u_s1 (
                .a_i(m[1]), .b_i(m[3]), .hi_o(p[1]), .lo_o(p[3]));
            topsel_cas #(.EW(EW), .KW(KW)) u_a0 (
                .a_i(p[0]), .b_i(p[1]), .hi_o(o[0]), .lo_o(o[1]));
            topsel_cas #(.EW(EW), .KW(KW)) u_a1 (
                .a_i(p[2]), .b_i(p[3]), .hi_o(o[2]), .lo_o(o[3]));
            for (genvar l = 4; l < LANES; l++) begin : g_pass
                assign o[l] = a[l];
            end
        end
    endcase
endmodule

// File: rtl/topsel.sv
module topsel
    import topsel_pkg::*;
#(
    parameter int N     = 16,
    parameter int KEY_W = 10,
    parameter int TAG_W = 4,
    parameter int DEPTH = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N*KEY_W-1:0] in_key,
    input  logic [N*TAG_W-1:0] in_tag,
    input  logic               in_vld,
    output logic [4*KEY_W-1:0] out_key,
    output logic [4*TAG_W-1:0] out_tag,
    output logic               out_vld
);
    localparam int IDX_W  = $clog2(N);
    localparam int KW     = KEY_W + IDX_W;
    localparam int EW     = KW + TAG_W;
    localparam int STAGES = stage_total(N);
    localparam int CW     = $clog2(DEPTH + 2) + 1;

    // entry layout: {key, inverted lane index, tag}
    logic [N*EW-1:0] entry_in;

    for (genvar l = 0; l < N; l++) begin : g_pack
        assign entry_in[l*EW +: EW] = {in_key[l*KEY_W +: KEY_W],
                                       ~IDX_W'(l),
                                       in_tag[l*TAG_W +: TAG_W]};
    end

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [N*EW-1:0] src;
        logic [N*EW-1:0] mix;
        logic [N*EW-1:0] q;
        logic            src_v;
        logic            q_v;

        if (s == 0) begin : g_head
            assign src   = entry_in;
            assign src_v = in_vld;
        end else begin : g_link
            assign src   = g_stage[s-1].q;
            assign src_v = g_stage[s-1].q_v;
        end

        topsel_step #(
            .LANES(N), .EW(EW), .KW(KW), .KIND(kind_of(s, STAGES))
        ) u_step (
            .bus_i(src),
            .bus_o(mix)
        );

        if (reg_after(s, STAGES, DEPTH)) begin : g_reg
            always_ff @(posedge clk) begin
                q <= mix;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q_v <= 1'b0;
                else        q_v <= src_v;
            end
        end else begin : g_wire
            assign q   = mix;
            assign q_v = src_v;
        end
    end

    logic [N*EW-1:0]  final_bus;
    logic [KEY_W-1:0] slot_key [4];
    logic [IDX_W-1:0] slot_idx [4];

    assign final_bus = g_stage[STAGES-1].q;
    assign out_vld   = g_stage[STAGES-1].q_v;

    for (genvar i = 0; i < 4; i++) begin : g_slot
        assign slot_key[i] = final_bus[i*EW + TAG_W + IDX_W +: KEY_W];
        assign slot_idx[i] = ~final_bus[i*EW + TAG_W +: IDX_W];
        assign out_key[i*KEY_W +: KEY_W] = slot_key[i];
        assign out_tag[i*TAG_W +: TAG_W] = final_bus[i*EW +: TAG_W];
    end

    logic unused_lanes;
    assign unused_lanes = ^final_bus[N*EW-1:4*EW];

    // ---------------- checks ----------------
    logic [CW-1:0] fill_cnt;
    logic [CW-1:0] pend_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_cnt <= '0;
            pend_cnt <= '0;
        end else begin
            if (fill_cnt < CW'(DEPTH)) fill_cnt <= fill_cnt + 1'b1;
            pend_cnt <= pend_cnt + CW'(in_vld) - CW'(out_vld);
        end
    end

    // R1
    slot_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (slot_key[0] >= slot_key[1]) && (slot_key[1] >= slot_key[2])
                    && (slot_key[2] >= slot_key[3]));

    // R3
    tie_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> ((slot_key[0] != slot_key[1]) || (slot_idx[0] < slot_idx[1]))
                 && ((slot_key[1] != slot_key[2]) || (slot_idx[1] < slot_idx[2]))
                 && ((slot_key[2] != slot_key[3]) || (slot_idx[2] < slot_idx[3])));

    // R4
    vld_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (pend_cnt != '0));

    // R4
    pend_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_cnt <= CW'(DEPTH));

    // R6
    fill_before_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (fill_cnt == CW'(DEPTH)));

endmodule

// File: tb/topsel_bench.sv
module topsel_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N     = 16;
    localparam int KW    = 10;
    localparam int TW    = 4;
    localparam int DEPTH = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N*KW-1:0] in_key = '0;
    logic [N*TW-1:0] in_tag = '0;
    logic            in_vld = 1'b0;
    logic [4*KW-1:0] out_key;
    logic [4*TW-1:0] out_tag;
    logic            out_vld;

    topsel #(.N(N), .KEY_W(KW), .TAG_W(TW), .DEPTH(DEPTH)) u_topsel (
        .clk(clk), .rst_n(rst_n), .in_key(in_key), .in_tag(in_tag),
        .in_vld(in_vld), .out_key(out_key), .out_tag(out_tag), .out_vld(out_vld));

    always #(CLK_PERIOD/2) clk = ~clk;

    int          checks = 0;
    int          fails  = 0;
    bit          finished = 0;
    int unsigned xs = 32'h2545f491;

    logic [4*KW-1:0] exp_k [0:63];
    logic [4*TW-1:0] exp_t [0:63];
    bit              exp_v [0:63];

    function automatic int unsigned rnd();
        xs = xs ^ (xs << 13);
        xs = xs ^ (xs >> 17);
        xs = xs ^ (xs << 5);
        return xs;
    endfunction

    function automatic int gen_key(input int mode, input int set, input int lane);
        case (mode)
            0:       return int'(rnd() % 1024);
            1:       return (set * 37) % 1024;
            2:       return lane * 60 + set;
            3:       return int'(rnd() % 4) * 100;
            default: return (rnd() % 5 == 0) ? 1023 : 0;
        endcase
    endfunction

    function automatic bit vld_of(input int vpat, input int c);
        case (vpat)
            0:       return 1'b1;
            1:       return (c % 2) == 0;
            default: return (c % 3) != 2;
        endcase
    endfunction

    // drives one set and computes its reference by repeated maximum selection
    task automatic drive_set(input int mode, input int set, input bit v);
        int  keys [N];
        bit  taken [N];
        for (int l = 0; l < N; l++) begin
            keys[l]  = gen_key(mode, set, l);
            taken[l] = 1'b0;
            in_key[l*KW +: KW] = KW'(keys[l]);
            in_tag[l*TW +: TW] = TW'(l ^ set);
        end
        in_vld = v;
        exp_v[set] = v;
        for (int k = 0; k < 4; k++) begin
            int best = -1;
            for (int l = 0; l < N; l++)
                if (!taken[l] && (best < 0 || keys[l] > keys[best])) best = l;
            taken[best] = 1'b1;
            exp_k[set][k*KW +: KW] = KW'(keys[best]);
            exp_t[set][k*TW +: TW] = TW'(best ^ set);
        end
    endtask

    task automatic check_set(input int set, input string req);
        bit ok;
        checks++;
        ok = (out_vld === exp_v[set]);
        if (exp_v[set]) ok = ok && (out_key === exp_k[set]) && (out_tag === exp_t[set]);
        if (!ok) begin
            fails++;
            $display("FAIL %s set %0d: got vld=%0b key=%h tag=%h, expected vld=%0b key=%h tag=%h",
                     req, set, out_vld, out_key, out_tag, exp_v[set],
                     exp_v[set] ? exp_k[set] : '0, exp_v[set] ? exp_t[set] : '0);
        end
    endtask

    task automatic check_idle(input string req);
        checks++;
        if (out_vld !== 1'b0) begin
            fails++;
            $display("FAIL %s: got out_vld=%0b, expected 0", req, out_vld);
        end
    endtask

    task automatic run_stream(input int cnt, input int mode, input int vpat, input string req);
        for (int c = 0; c < cnt + DEPTH; c++) begin
            @(negedge clk);
            if (c >= DEPTH) check_set(c - DEPTH, req);
            if (c < cnt) drive_set(mode, c, vld_of(vpat, c));
            else in_vld = 1'b0;
        end
    endtask

    // R6: reset holds the valid pipeline empty
    task automatic test_reset();
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            drive_set(0, c, 1'b1);
            check_idle("R6 during reset");
        end
        @(negedge clk);
        in_vld = 1'b0;
        rst_n  = 1'b1;
        for (int c = 0; c < DEPTH + 2; c++) begin
            @(negedge clk);
            check_idle("R6 after release");
        end
    endtask

    // R6: sets in flight at reset never appear
    task automatic test_reset_in_flight();
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            drive_set(0, c, 1'b1);
        end
        @(negedge clk);
        in_vld = 1'b0;
        rst_n  = 1'b0;
        #1;
        check_idle("R6 reset asserted");
        @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < DEPTH + 1; c++) begin
            @(negedge clk);
            check_idle("R6 flushed");
        end
    endtask

    task automatic test_random();
        run_stream(24, 0, 0, "R1 R2 R4 random");
    endtask

    task automatic test_ties();
        run_stream(8, 1, 0, "R3 all equal");
        run_stream(12, 3, 0, "R3 few values");
    endtask

    task automatic test_place();
        run_stream(6, 2, 0, "R1 top in last lanes");
        run_stream(10, 4, 0, "R1 extremes");
    endtask

    task automatic test_bubbles();
        run_stream(20, 0, 1, "R5 alternate");
        run_stream(18, 3, 2, "R5 irregular");
    endtask

    initial begin
        test_reset();
        test_random();
        test_ties();
        test_place();
        test_bubbles();
        test_reset_in_flight();
        test_random();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: got no completion, expected end of run");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule